// File: doc/BRIEF.md
# DCS Read Engine with Power-Mode Decode

This block runs register read transactions toward a display controller over a four-wire serial link that uses 8-bit words and a separate data/command select line. A host pulses a request carrying a command code and a reply length. The engine lowers the chip select and drives the command byte with the data/command line low. It then clocks in the reply and returns the received bytes on a parallel bus, together with a one-cycle completion pulse.

Two of the read commands, identification and status, are answered by the panel one bit late: a dummy clock comes before the first real data bit. For these commands the engine clocks in one extra byte and realigns the whole reply by one bit before handing it out. They accept only 3- or 4-byte replies. When the power-mode register is read, the engine also decodes the first reply byte into a display-on flag, ignoring the reserved bits. A driver can use this flag to skip a visible re-initialisation when the panel is already running.

The serial clock rate is fixed at elaboration from the system clock and the link's maximum rate. Codes outside the read list and illegal lengths are refused at once with an error pulse, and the link stays untouched.

Top module: `dcs_read_engine`

## Requirements
- R1: While a transaction runs, every high and every low phase of `sclk` lasts H system cycles, where H = ceil(SYS_CLK_HZ / (2·F)) and F = min(2 MHz, MAX_SCLK_HZ/2). While `csx` is high, `sclk` is low.
- R2: The command byte is shifted out on `mosi` MSB first, one bit per `sclk` period, with the bit stable at each rising edge. `dcx` is low whenever `csx` is low.
- R3: Only these 20 codes are reads: 0x04, 0x06–0x0F, 0x2E, 0x3E, 0x45, 0x52, 0x54, 0x56, 0x5F, 0xA1, 0xA8. Any other code raises `err` for one cycle in the cycle after the request. In that case `csx` stays high, `done` does not pulse and `rd_data` keeps its value.
- R4: A length of 0 or above MAX_BYTES is refused with `err` for every command. Commands 0x04 and 0x09 are also refused unless the length is 3 or 4.
- R5: For 0x04 and 0x09 the engine clocks 8·(len+1) reply bits. Output byte i is (raw[i] << 1) | raw[i+1][7], where raw[k] is the k-th byte on the wire.
- R6: Every other read clocks exactly 8·len reply bits and returns them unshifted. Byte i, the i-th received byte, sits at `rd_data[8i+7:8i]`, and bytes at or above len read as zero.
- R7: `miso` is sampled on each rising `sclk` edge, MSB of each byte first.
- R8: `done` is a one-cycle pulse in the cycle where `csx` returns high after the final falling `sclk` edge. `rd_data` holds the result from that cycle on.
- R9: Completing a 0x0A read sets `display_on` to 1 exactly when (byte0 AND 0x7C) equals 0x1C, meaning bits 2, 3 and 4 are set and bits 5 and 6 are clear. Bits 0, 1 and 7 have no effect.
- R10: `display_on` is 0 after reset and changes only in a cycle where `done` pulses for a 0x0A read.
- R11: `req_valid` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-cycle request strobe, taken only when idle |
| req_cmd | input | 8 | Read command code |
| req_len | input | LEN_W | Number of reply bytes wanted |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle refusal pulse |
| rd_data | output | 8·MAX_BYTES | Received bytes, byte 0 in the low bits |
| display_on | output | 1 | Decoded power-mode result |
| sclk | output | 1 | Serial clock, idle low |
| csx | output | 1 | Chip select, active low |
| dcx | output | 1 | Data/command select, low for the whole read |
| mosi | output | 1 | Serial data to the panel |
| miso | input | 1 | Serial data from the panel |

## Verification
The bench builds the engine with SYS_CLK_HZ = 16 MHz and MAX_SCLK_HZ = 8 MHz, so half of the link limit (4 MHz) is above the 2 MHz ceiling. The ceiling therefore sets the clock, and each phase lasts four system cycles, which keeps every transaction short. MAX_BYTES stays at 4, so both legal lengths of the dummy-bit commands fit. Refusal of an over-long length (5) is reachable through the 4-bit length port.

// File: rtl/dcs_rd_pkg.sv
package dcs_rd_pkg;

  localparam logic [7:0] CMD_IDENT  = 8'h04;
  localparam logic [7:0] CMD_STATUS = 8'h09;
  localparam logic [7:0] CMD_POWER  = 8'h0A;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CMD  = 2'd1,
    ST_RESP = 2'd2
  } dcs_rd_state_e;

  // Membership of the read list, grouped by range.
  function automatic logic dcs_is_read(input logic [7:0] c);
    logic hit;
    hit = 1'b0;
    if (c == 8'h04) hit = 1'b1;
    if (c >= 8'h06 && c <= 8'h0F) hit = 1'b1;
    case (c)
      8'h2E, 8'h3E, 8'h45, 8'h52, 8'h54, 8'h56, 8'h5F, 8'hA1, 8'hA8: hit = 1'b1;
      default: ;
    endcase
    return hit;
  endfunction

  // Commands whose reply is preceded by one dummy bit.
  function automatic logic dcs_has_dummy(input logic [7:0] c);
    return (c == CMD_IDENT) || (c == CMD_STATUS);
  endfunction

  // Half period of the read clock in system cycles.
  function automatic int unsigned sclk_half(input int unsigned sys_hz,
                                            input int unsigned max_hz,
                                            input int unsigned cap_hz);
    int unsigned tgt;
    int unsigned h;
    tgt = (max_hz / 2 < cap_hz) ? max_hz / 2 : cap_hz;
    if (tgt == 0) tgt = 1;
    h = (sys_hz + 2 * tgt - 1) / (2 * tgt);
    return (h == 0) ? 1 : h;
  endfunction

  // Power-mode decode: reserved bits 0, 1 and 7 are masked off.
  function automatic logic pwr_is_on(input logic [7:0] b);
    return (b & 8'h7C) == 8'h1C;
  endfunction

endpackage

// File: rtl/dcs_rd_clkdiv.sv
module dcs_rd_clkdiv #(
  parameter int unsigned HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int unsigned CW = (HALF < 2) ? 1 : $clog2(HALF);

  logic [CW-1:0] cnt;

  assign tick = en && (cnt == CW'(HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!en)    cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/dcs_rd_classify.sv
module dcs_rd_classify
  import dcs_rd_pkg::*;
#(
  parameter int unsigned MAX_BYTES = 4,
  parameter int unsigned LEN_W     = 4
) (
  input  logic [7:0]       cmd,
  input  logic [LEN_W-1:0] len,
  output logic             ok,
  output logic             dummy
);
  logic is_rd;
  logic len_fits;
  logic dummy_len_ok;

  assign is_rd        = dcs_is_read(cmd);
  assign dummy        = dcs_has_dummy(cmd);
  assign len_fits     = (len != '0) && (len <= LEN_W'(MAX_BYTES));
  assign dummy_len_ok = (len == LEN_W'(3)) || (len == LEN_W'(4));
  assign ok           = is_rd && len_fits && (!dummy || dummy_len_ok);
endmodule

// File: rtl/dcs_rd_pack.sv
module dcs_rd_pack #(
  parameter int unsigned MAX_BYTES = 4,
  parameter int unsigned LEN_W     = 4,
  parameter int unsigned SR_W      = (MAX_BYTES + 1) * 8
) (
  input  logic [SR_W-1:0]        sr,
  input  logic [LEN_W-1:0]       len,
  input  logic                   dummy,
  output logic [MAX_BYTES*8-1:0] data
);
  // Raw byte k sits at sr[(nraw-1-k)*8 +: 8]; with a dummy bit the output
  // byte takes the lower seven bits plus the MSB of the following raw byte.
  function automatic logic [MAX_BYTES*8-1:0] realign(input logic [SR_W-1:0] s,
                                                     input int n,
                                                     input logic d);
    logic [MAX_BYTES*8-1:0] r;
    logic [7:0] hi;
    int nraw;
    int at;
    r    = '0;
    nraw = n + (d ? 1 : 0);
    for (int i = 0; i < int'(MAX_BYTES); i++) begin
      if (i < n) begin
        at = (nraw - 1 - i) * 8;
        hi = s[at +: 8];
        if (d) r[i*8 +: 8] = {hi[6:0], s[at-1]};
        else   r[i*8 +: 8] = hi;
      end
    end
    return r;
  endfunction

  assign data = realign(sr, int'(len), dummy);
endmodule

// File: rtl/dcs_read_engine.sv
module dcs_read_engine
  import dcs_rd_pkg::*;
#(
  parameter int unsigned SYS_CLK_HZ  = 100_000_000,
  parameter int unsigned MAX_SCLK_HZ = 10_000_000,
  parameter int unsigned READ_CAP_HZ = 2_000_000,
  parameter int unsigned MAX_BYTES   = 4,
  parameter int unsigned LEN_W       = $clog2(MAX_BYTES + 1) + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic [7:0]             req_cmd,
  input  logic [LEN_W-1:0]       req_len,
  output logic                   busy,
  output logic                   done,
  output logic                   err,
  output logic [MAX_BYTES*8-1:0] rd_data,
  output logic                   display_on,
  output logic                   sclk,
  output logic                   csx,
  output logic                   dcx,
  output logic                   mosi,
  input  logic                   miso
);
  localparam int unsigned HALF  = sclk_half(SYS_CLK_HZ, MAX_SCLK_HZ, READ_CAP_HZ);
  localparam int unsigned SR_W  = (MAX_BYTES + 1) * 8;
  localparam int unsigned CNT_W = $clog2(SR_W + 1);

  dcs_rd_state_e          state;
  logic                   sclk_q, csx_q, dcx_q, mosi_q;
  logic [6:0]             tx_sh;
  logic [CNT_W-1:0]       bit_cnt, bits_total;
  logic [SR_W-1:0]        sr;
  logic [LEN_W-1:0]       len_q;
  logic                   dummy_q;
  logic [7:0]             cmd_q;
  logic [MAX_BYTES*8-1:0] rd_data_q;
  logic                   on_q, done_q, err_q;

  logic                   tick;
  logic                   cls_ok, cls_dummy;
  logic [MAX_BYTES*8-1:0] pack_data;
  logic                   running;

  assign running = (state != ST_IDLE);

  dcs_rd_clkdiv #(.HALF(HALF)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (running),
    .tick  (tick)
  );

  dcs_rd_classify #(.MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W)) u_cls (
    .cmd   (req_cmd),
    .len   (req_len),
    .ok    (cls_ok),
    .dummy (cls_dummy)
  );

  dcs_rd_pack #(.MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W), .SR_W(SR_W)) u_pack (
    .sr    (sr),
    .len   (len_q),
    .dummy (dummy_q),
    .data  (pack_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      sclk_q     <= 1'b0;
      csx_q      <= 1'b1;
      dcx_q      <= 1'b1;
      mosi_q     <= 1'b0;
      tx_sh      <= '0;
      bit_cnt    <= '0;
      bits_total <= '0;
      sr         <= '0;
      len_q      <= '0;
      dummy_q    <= 1'b0;
      cmd_q      <= '0;
      rd_data_q  <= '0;
      on_q       <= 1'b0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            if (cls_ok) begin
              state      <= ST_CMD;
              csx_q      <= 1'b0;
              dcx_q      <= 1'b0;
              mosi_q     <= req_cmd[7];
              tx_sh      <= req_cmd[6:0];
              bit_cnt    <= '0;
              cmd_q      <= req_cmd;
              len_q      <= req_len;
              dummy_q    <= cls_dummy;
              bits_total <= CNT_W'((int'(req_len) + (cls_dummy ? 1 : 0)) * 8);
              sr         <= '0;
            end else begin
              err_q <= 1'b1;
            end
          end
        end
        ST_CMD: begin
          if (tick) begin
            if (!sclk_q) begin
              sclk_q  <= 1'b1;
              bit_cnt <= bit_cnt + 1'b1;
            end else begin
              sclk_q <= 1'b0;
              if (bit_cnt == CNT_W'(8)) begin
                state   <= ST_RESP;
                bit_cnt <= '0;
                mosi_q  <= 1'b0;
              end else begin
                mosi_q <= tx_sh[6];
                tx_sh  <= {tx_sh[5:0], 1'b0};
              end
            end
          end
        end
        ST_RESP: begin
          if (tick) begin
            if (!sclk_q) begin
              sclk_q  <= 1'b1;
              sr      <= {sr[SR_W-2:0], miso};
              bit_cnt <= bit_cnt + 1'b1;
            end else begin
              sclk_q <= 1'b0;
              if (bit_cnt == bits_total) begin
                state     <= ST_IDLE;
                csx_q     <= 1'b1;
                dcx_q     <= 1'b1;
                done_q    <= 1'b1;
                rd_data_q <= pack_data;
                if (cmd_q == CMD_POWER) on_q <= pwr_is_on(pack_data[7:0]);
              end
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy       = running;
  assign done       = done_q;
  assign err        = err_q;
  assign rd_data    = rd_data_q;
  assign display_on = on_q;
  assign sclk       = sclk_q;
  assign csx        = csx_q;
  assign dcx        = dcx_q;
  assign mosi       = mosi_q;
endmodule

// File: rtl/dcs_read_engine_chk.sv
module dcs_read_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       busy,
  input logic       csx,
  input logic       dcx,
  input logic       sclk,
  input logic       done,
  input logic       err,
  input logic       display_on,
  input logic [7:0] cmd_lat
);
  AST_SCLK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    csx |-> !sclk);                                         // R1
  AST_DCX_LOW_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !csx |-> !dcx);                                         // R2
  AST_ERR_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (csx && !busy && !done));                       // R3
  AST_CSX_FALL_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(csx) |-> $past(req_valid));                       // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                        // R8
  AST_DONE_BUS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (csx && !sclk && !busy));                      // R8
  AST_ON_CHANGES_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(display_on) |-> (done && cmd_lat == 8'h0A));   // R10
  AST_CMD_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy ##1 busy |-> $stable(cmd_lat));                    // R11
endmodule

bind dcs_read_engine dcs_read_engine_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .busy       (busy),
  .csx        (csx),
  .dcx        (dcx),
  .sclk       (sclk),
  .done       (done),
  .err        (err),
  .display_on (display_on),
  .cmd_lat    (cmd_q)
);

// File: tb/dcs_read_engine_tb.sv
module dcs_read_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SYS_HZ     = 16_000_000;
  localparam int MAX_HZ     = 8_000_000;
  localparam int NBYTES     = 4;
  localparam int LW         = 4;
  // Independent half-phase figure: 2 MHz ceiling wins over 4 MHz.
  localparam int EXP_HALF   = (MAX_HZ / 2 > 2_000_000) ? SYS_HZ / 4_000_000 : SYS_HZ / MAX_HZ;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0;
  logic [7:0] req_cmd = 0;
  logic [LW-1:0] req_len = 0;
  logic busy, done, err, display_on, sclk, csx, dcx, mosi;
  logic miso = 0;
  logic [NBYTES*8-1:0] rd_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  dcs_read_engine #(
    .SYS_CLK_HZ(SYS_HZ), .MAX_SCLK_HZ(MAX_HZ), .READ_CAP_HZ(2_000_000),
    .MAX_BYTES(NBYTES), .LEN_W(LW)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_len(req_len), .busy(busy), .done(done), .err(err), .rd_data(rd_data),
    .display_on(display_on), .sclk(sclk), .csx(csx), .dcx(dcx), .mosi(mosi),
    .miso(miso)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- panel model ----------------
  logic [47:0] stream = '0;  // stream[k] is the k-th reply bit on the wire
  int pos = 0;
  logic [7:0] cmd_rx = 0;
  int csx_starts = 0, dcx_bad = 0;
  time t_rise = 0, t_fall = 0, hi_w = 0, lo_w = 0;

  initial forever begin
    @(negedge csx);
    pos = 0; cmd_rx = 0; csx_starts++;
  end
  initial forever begin
    @(posedge sclk);
    if (pos > 0) lo_w = $time - t_fall;
    t_rise = $time;
    if (pos < 8) cmd_rx = {cmd_rx[6:0], mosi};
    if (dcx !== 1'b0) dcx_bad++;
    pos++;
  end
  initial forever begin
    @(negedge sclk);
    hi_w = $time - t_rise;
    t_fall = $time;
    if (pos >= 8 && pos - 8 < 48) miso = stream[pos-8];
  end

  // ---------------- scoreboard ----------------
  typedef struct {
    logic [7:0]  cmd;
    bit          exp_err;
    logic [31:0] data;
    bit          on;
    string       tag;
  } exp_t;
  exp_t sb[$];

  initial forever begin
    @(posedge clk); #1;
    if (done || err) begin
      if (sb.size() == 0) begin
        chk(0, "R11 unexpected completion", {30'd0, done, err}, 32'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(err == e.exp_err, {e.tag, " err flag"}, {31'd0, err}, {31'd0, e.exp_err});
        chk(csx == 1'b1, "R3/R8 csx high at completion", {31'd0, csx}, 32'd1);
        if (!e.exp_err) begin
          chk(rd_data == e.data, {e.tag, " rd_data"}, rd_data, e.data);
          chk(cmd_rx == e.cmd, "R2 command byte on mosi", {24'd0, cmd_rx}, {24'd0, e.cmd});
          chk(display_on == e.on, {e.tag, " display_on"}, {31'd0, display_on}, {31'd0, e.on});
        end
        @(posedge clk); #1;
        chk(!done && !err, "R8 single-cycle pulse", {30'd0, done, err}, 32'd0);
      end
    end
  end

  bit on_model = 0;

  task automatic run(input logic [7:0] cmd, input int len, input logic [31:0] bytes,
                     input bit dly, input bit exp_err, input string tag);
    exp_t e;
    int k;
    stream = '0;
    k = 0;
    if (dly) begin stream[0] = 1'b1; k = 1; end
    for (int b = 0; b < len && b < NBYTES; b++)
      for (int j = 7; j >= 0; j--) begin stream[k] = bytes[b*8+j]; k++; end
    if (dly) for (int j = 0; j < 7; j++) begin stream[k] = j[0]; k++; end
    e.cmd = cmd; e.exp_err = exp_err; e.tag = tag; e.data = '0;
    for (int b = 0; b < len && b < NBYTES; b++) e.data[b*8 +: 8] = bytes[b*8 +: 8];
    if (!exp_err && cmd == 8'h0A) on_model = ((bytes[7:0] & 8'h7C) == 8'h1C);
    e.on = on_model;
    sb.push_back(e);
    @(negedge clk);
    req_valid = 1; req_cmd = cmd; req_len = LW'(len);
    @(negedge clk);
    req_valid = 0;
    while (sb.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int starts;
    logic [31:0] held;
    repeat (4) @(negedge clk);
    // reset state: R1 R10
    chk(csx == 1 && sclk == 0 && busy == 0, "R1 idle bus after reset", {29'd0, csx, sclk, busy}, 32'b100);
    chk(display_on == 0 && done == 0 && err == 0, "R10 reset flags", {29'd0, display_on, done, err}, 32'd0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R9: reserved bits 0,1,7 set, core bits on
    run(8'h0A, 1, 32'h9F, 0, 0, "R9 power on with reserved bits");
    chk(hi_w == EXP_HALF * CLK_PERIOD, "R1 high phase", hi_w[31:0], EXP_HALF * CLK_PERIOD);
    chk(lo_w == EXP_HALF * CLK_PERIOD, "R1 low phase", lo_w[31:0], EXP_HALF * CLK_PERIOD);
    chk(dcx_bad == 0, "R2 dcx low at every rising edge", dcx_bad, 0);
    run(8'h0A, 1, 32'h3C, 0, 0, "R9 partial bit set -> off");
    run(8'h0A, 1, 32'h1C, 0, 0, "R9 exact pattern -> on");
    // R6 R7 R10: plain read, display_on must hold
    run(8'h0C, 2, 32'hAA55, 0, 0, "R6 R10 plain two-byte read");
    run(8'h2E, 4, 32'hC3A50F81, 0, 0, "R6 R7 four-byte memory read");
    run(8'hA8, 1, 32'h01, 0, 0, "R6 last list entry");
    // R5: dummy-bit commands
    run(8'h04, 3, 32'h563412, 1, 0, "R5 ident three bytes");
    run(8'h09, 4, 32'h80FF0170, 1, 0, "R5 status four bytes");
    // R3 R4 refusals
    starts = csx_starts;
    held = rd_data;
    run(8'h2A, 1, 32'h0, 0, 1, "R3 non-read code refused");
    run(8'h04, 2, 32'h0, 1, 1, "R4 ident length 2 refused");
    run(8'h09, 5, 32'h0, 1, 1, "R4 status length 5 refused");
    run(8'h0B, 0, 32'h0, 0, 1, "R4 zero length refused");
    run(8'h0B, 5, 32'h0, 0, 1, "R4 over-long length refused");
    chk(csx_starts == starts, "R3 no bus cycle on refusal", csx_starts, starts);
    chk(rd_data == held, "R3 rd_data kept on refusal", rd_data, held);
    // R11: request while busy is ignored
    begin
      exp_t e;
      stream = '0;
      for (int j = 0; j < 8; j++) stream[j] = 8'h48 >> (7 - j);
      e.cmd = 8'h0B; e.exp_err = 0; e.data = 32'h48; e.on = on_model; e.tag = "R11 busy request ignored";
      sb.push_back(e);
      @(negedge clk); req_valid = 1; req_cmd = 8'h0B; req_len = 1;
      @(negedge clk); req_valid = 0;
      repeat (20) @(negedge clk);
      chk(busy == 1, "R11 engine busy", {31'd0, busy}, 32'd1);
      req_valid = 1; req_cmd = 8'h0A; req_len = 1;
      @(negedge clk); req_valid = 0;
      while (sb.size() != 0) @(negedge clk);
      repeat (40) @(negedge clk);
      chk(busy == 0 && csx == 1, "R11 no second transaction", {30'd0, busy, csx}, 32'b01);
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule